// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that software drives through one 8-bit control register. While its run bit is set, it counts system clocks. When the count reaches a selectable power-of-two timeout, it sets a sticky interrupt flag. A fixed 512 clocks after that, it can emit a one-cycle watchdog reset pulse. Software services the watchdog by writing the restart bit, which returns the count to zero before either stage is reached.

A second sticky flag records that the watchdog caused a reset. The pulse itself clears the counter, the run bit and the reset-enable bit, but it leaves the cause flag alone. Only a software write of 0 or the power-on/power-fail reset input clears that flag, so code that runs after the reset can see why it happened.

The parameter `EXP_SHIFT` lowers all four timeout exponents by the same amount, so that short simulations can reach every timeout. The 512-clock gap is set by `GAP` and does not change with `EXP_SHIFT`.

Top module: `wdog_two_stage`

## Requirements
- R1: After `por_n` is low, `rd_data` reads 0x00 and both `irq` and `wd_rst` are low.
- R2: The control register bits are: bit 7 run, bit 6 reserved, bits 5:4 timeout select, bit 3 interrupt flag, bit 2 watchdog-reset flag, bit 1 reset enable, bit 0 restart. Bits 6 and 0 always read 0. A write loads run, select and reset enable directly.
- R3: After a restart with run set, the interrupt flag becomes 1 exactly 2^(17-EXP_SHIFT+3*sel) running clocks later, where sel is the 2-bit select value 0 to 3.
- R4: `irq` is high exactly when the interrupt flag is 1 and `wd_int_en` is high.
- R5: Once set, the interrupt flag stays 1 until a write with bit 3 = 0. A write with bit 3 = 1 neither sets it nor clears it.
- R6: With reset enable set, `wd_rst` pulses high for exactly one cycle GAP (512) running clocks after the interrupt timeout. The same edge sets the reset flag and clears run, reset enable and the counter. Select and the interrupt flag are kept.
- R7: With reset enable 0, no pulse occurs and the reset flag stays 0. At the point where the reset would have happened, the counter returns to 0 and keeps counting.
- R8: Writing 1 to bit 0 sets the counter to 0, and this takes priority over counting in that cycle.
- R9: While run is 0, the counter holds its value. Clearing run and then setting it again resumes the count from where it stopped.
- R10: Once set, the reset flag stays 1 until a write with bit 2 = 0 or a low `por_n`. A write with bit 2 = 1 does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on/power-fail reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| wd_int_en | input | 1 | External watchdog interrupt enable |
| irq | output | 1 | Watchdog interrupt request |
| wd_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The timeout is exercised with every select code. The flag is sampled one clock before its expected edge and again on it, so an off-by-one count or a wrong exponent shows up. The second stage is run for two select codes with reset enable set and once with it clear. This separates a gap measured from the interrupt point from one measured from the restart, and checks that the wrap still re-arms the interrupt when no reset is taken. Runs that are restarted mid-count and runs that are paused mid-count check that a restart clears the count while a pause preserves it.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int EXP_SHIFT = 0,
  parameter int GAP       = 512
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       wd_int_en,
  output logic       irq,
  output logic       wd_rst
);
  localparam int EMIN = 17 - EXP_SHIFT;
  localparam int EMAX = EMIN + 9;
  localparam int CW   = EMAX + 1;

  logic          run_q, rst_en_q, wdif_q, wrf_q, wd_rst_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] cnt_q, t_int, t_end;

  assign t_int = CW'(1) << (EMIN + 3 * int'(sel_q));
  assign t_end = t_int + CW'(GAP);

  wire restart = wr_en & wr_data[0];
  wire tick    = run_q & ~restart;
  wire hit_int = tick && (cnt_q == t_int - CW'(1));
  wire hit_end = tick && (cnt_q == t_end - CW'(1));
  wire fire    = hit_end & rst_en_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                cnt_q <= '0;
    else if (restart || hit_end) cnt_q <= '0;
    else if (tick)             cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_q    <= 1'b0;
      rst_en_q <= 1'b0;
      sel_q    <= 2'b00;
    end else if (fire) begin
      run_q    <= 1'b0;
      rst_en_q <= 1'b0;
    end else if (wr_en) begin
      run_q    <= wr_data[7];
      sel_q    <= wr_data[5:4];
      rst_en_q <= wr_data[1];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wdif_q   <= 1'b0;
      wrf_q    <= 1'b0;
      wd_rst_q <= 1'b0;
    end else begin
      wd_rst_q <= fire;
      if (hit_int)                    wdif_q <= 1'b1;
      else if (wr_en && !wr_data[3])  wdif_q <= 1'b0;
      if (fire)                       wrf_q <= 1'b1;
      else if (wr_en && !wr_data[2])  wrf_q <= 1'b0;
    end
  end

  assign rd_data = {run_q, 1'b0, sel_q, wdif_q, wrf_q, rst_en_q, 1'b0};
  assign irq     = wdif_q & wd_int_en;
  assign wd_rst  = wd_rst_q;

  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    wd_rst |=> !wd_rst);
  // R6
  rst_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wd_rst) |-> ($past(rst_en_q) && $past(run_q) && wrf_q));
  // R7
  no_rst_when_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_en_q |=> !wd_rst);
  // R5
  int_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wdif_q && !(wr_en && !wr_data[3])) |=> wdif_q);
  // R10
  rst_flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wrf_q && !(wr_en && !wr_data[2])) |=> wrf_q);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!run_q && !restart) |=> $stable(cnt_q));
  // R3
  int_only_running_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdif_q) |-> $past(run_q));
endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SHIFT      = 12;
  localparam int GAP        = 512;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wd_int_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq, wd_rst;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done   = 1'b0;

  wdog_two_stage #(.EXP_SHIFT(SHIFT), .GAP(GAP)) dut_i (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wd_int_en(wd_int_en), .irq(irq), .wd_rst(wd_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (por_n && wd_rst) pulses++;

  function automatic int tmo(input int sel);
    return 1 << (17 - SHIFT + 3 * sel);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_por();
    por_n = 1'b0;
    edges(2);
    por_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wd_rst", wd_rst, 1'b0);
  endtask

  task automatic t_layout();
    wr(8'hFF);
    chk("R2 write all ones", rd_data, 8'hB2);
    chk("R5 write 1 does not set flag", rd_data[3], 1'b0);
    wr(8'h00);
    chk("R2 write zeros", rd_data, 8'h00);
  endtask

  task automatic t_timeout(input int sel);
    int t = tmo(sel);
    wr(8'h81 | 8'(sel << 4));
    edges(t - 1);
    chk($sformatf("R3 sel%0d flag before", sel), rd_data[3], 1'b0);
    edges(1);
    chk($sformatf("R3 sel%0d flag at timeout", sel), rd_data[3], 1'b1);
    wr(8'h00);
    chk($sformatf("R5 sel%0d cleared by 0", sel), rd_data, 8'h00);
  endtask

  task automatic t_irq();
    wr(8'h81);
    edges(tmo(0));
    wd_int_en = 1'b0;
    #1 chk("R4 irq gated off", irq, 1'b0);
    wd_int_en = 1'b1;
    #1 chk("R4 irq enabled", irq, 1'b1);
    wr(8'h08);
    chk("R5 write 1 keeps flag", rd_data[3], 1'b1);
    chk("R4 irq still high", irq, 1'b1);
    wr(8'h00);
    chk("R4 irq after clear", irq, 1'b0);
    wd_int_en = 1'b0;
  endtask

  task automatic t_reset_seq(input int sel);
    int t = tmo(sel);
    int p0 = pulses;
    wr(8'h83 | 8'(sel << 4));
    edges(t + GAP - 1);
    chk($sformatf("R6 sel%0d no pulse early", sel), wd_rst, 1'b0);
    chk($sformatf("R6 sel%0d flag set earlier", sel), rd_data[3], 1'b1);
    edges(1);
    chk($sformatf("R6 sel%0d pulse", sel), wd_rst, 1'b1);
    chk($sformatf("R6 sel%0d reg after pulse", sel), rd_data, 8'h0C | 8'(sel << 4));
    edges(1);
    chk($sformatf("R6 sel%0d pulse ends", sel), wd_rst, 1'b0);
    edges(t + GAP + 20);
    chk($sformatf("R6 sel%0d single pulse", sel), pulses - p0, 1);
    wr(8'h04 | 8'(sel << 4));
    chk($sformatf("R10 sel%0d keep wrf", sel), rd_data, 8'h04 | 8'(sel << 4));
    wr(8'h00);
    chk($sformatf("R10 sel%0d clear wrf", sel), rd_data, 8'h00);
  endtask

  task automatic t_por_clears();
    wr(8'h83);
    edges(tmo(0) + GAP + 2);
    chk("R10 wrf set before por", rd_data[2], 1'b1);
    do_por();
    chk("R10 por clears wrf", rd_data, 8'h00);
  endtask

  task automatic t_no_reset();
    int t = tmo(0);
    int p0 = pulses;
    wr(8'h81);
    edges(t + GAP);
    chk("R7 no pulse", pulses - p0, 0);
    chk("R7 reg still running", rd_data, 8'h88);
    wr(8'h80);
    edges(t - 2);
    chk("R7 flag before rewrap", rd_data[3], 1'b0);
    edges(1);
    chk("R7 flag after rewrap", rd_data[3], 1'b1);
    wr(8'h00);
  endtask

  task automatic t_restart();
    int t = tmo(0);
    wr(8'h81);
    edges(t - 2);
    wr(8'h81);
    edges(t - 1);
    chk("R8 flag not set after restart", rd_data[3], 1'b0);
    edges(1);
    chk("R8 flag at restarted timeout", rd_data[3], 1'b1);
    wr(8'h00);
  endtask

  task automatic t_hold();
    int t = tmo(0);
    wr(8'h81);
    edges(10);
    wr(8'h00);
    edges(100);
    chk("R9 no flag while stopped", rd_data[3], 1'b0);
    wr(8'h80);
    edges(t - 12);
    chk("R9 flag before resumed timeout", rd_data[3], 1'b0);
    edges(1);
    chk("R9 flag at resumed timeout", rd_data[3], 1'b1);
    wr(8'h00);
  endtask

  initial begin
    edges(3);
    t_reset();
    por_n = 1'b1;
    edges(1);
    t_reset();
    t_layout();
    for (int s = 0; s < 4; s++) t_timeout(s);
    t_irq();
    t_reset_seq(0);
    t_reset_seq(1);
    t_por_clears();
    t_no_reset();
    t_restart();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule